// File: doc/BRIEF.md
# Caption Line Data Capture Unit

This block collects 16-bit caption payloads from digitised video lines. A serial data bit arrives with a one-cycle data-clock strobe and is shifted into a 16-bit word, least significant bit first. The block counts lines itself. A falling edge on the vertical-sync-separated input restarts the count at line 0. Each line-start pulse closes the current line and opens the next one, so the first line after a sync fall is line 1.

When a line closes, the word shifted in during that line can be copied into one of two byte-pair registers, each with its own completion flag. A 2-bit mode field decides which line feeds which pair: the fixed caption line 21, or a line chosen by a 5-bit programmed number. The same field decides which line's end raises a one-cycle interrupt request. Software reads the four bytes and the flag byte through a small combinational read port. A sync fall wipes every pair and flag.

Top module: `cc_capture`

## Requirements
- R1: On each cycle with `data_stb` high and no line start or sync fall, `data_bit` enters the word from the top and the word moves one place toward bit 0. The word is cleared at every line start and every sync fall, and a bit strobed in the same cycle as a line start is dropped. The word latched for a line is therefore the last 16 bits of that line, with the earliest of them in bit 0.
- R2: Read map, combinational on `rd_addr`: 0 = pair A low byte (word bits 7:0), 1 = pair A high byte, 2 = pair B low byte, 3 = pair B high byte, 4 = flag byte with bit 0 = flag A and bit 1 = flag B. Addresses 5 to 7 read zero.
- R3: A sync fall (`vsep` high in the previous cycle and low now) sets the line count to 0. Each `line_start` ends the line whose number is the current count and then increments the count, which saturates at 63. A programmed line number of 0 never matches.
- R4: In modes 00 and 11, the end of line 21 loads pair A and sets flag A, and the end of the programmed line loads pair B and sets flag B. If the programmed line is 21, both pairs load.
- R5: In mode 01, the end of the programmed line loads pair A and sets flag A. Pair B and flag B keep their values.
- R6: In mode 10, the end of line 21 loads pair A and sets flag A. Pair B and flag B keep their values.
- R7: `irq` is high for exactly one cycle, the cycle after the edge that samples the line start ending the selected line. The selected line is the programmed line in mode 01 and line 21 in the other modes. Pair A and flag A are already updated in that cycle.
- R8: A sync fall clears all four data bytes and both flags at the next edge. It takes precedence over a line start in the same cycle: nothing is latched and no `irq` is raised.
- R9: Pair contents change only at a line end or a sync fall. Bits arriving mid-line are never visible on the read port.
- R10: After reset, every readable byte is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsep | input | 1 | Vertical-sync-separated level; a falling edge starts a field |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| data_stb | input | 1 | Data-clock strobe, one cycle per bit |
| data_bit | input | 1 | Digitised caption bit |
| mode | input | 2 | Slice-line routing mode |
| prog_line | input | 5 | Programmed line number |
| rd_addr | input | 3 | Read port address |
| rd_data | output | 8 | Read port data |
| irq | output | 1 | One-cycle end-of-line interrupt request |

## Verification
The bench sweeps every mode against programmed lines 0, 3, 21 and 31. It closes 34 lines per field, and each line carries a distinct word padded with a varying number of junk bits. The checks target the following faults:
- A programmed value of 0 or 21 colliding with the line count or the fixed line would load the wrong pair.
- A mode 01 or 10 design that touched pair B would show a nonzero byte at addresses 2 and 3.
- Shifting in the wrong direction, or keeping junk bits across a line start, would produce byte-swapped or shifted data.
- Reads in mid-line show whether partial words leak onto the read port.
- A sync fall landing on the line-21 line start shows whether the clear really wins over the latch and the interrupt.

// File: rtl/cc_cap_pkg.sv
package cc_cap_pkg;

  typedef enum logic [1:0] {
    MODE_DUAL      = 2'b00,
    MODE_PROG_ONLY = 2'b01,
    MODE_CC_ONLY   = 2'b10,
    MODE_DUAL_ALT  = 2'b11
  } slice_mode_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_A_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_A_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_B_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_B_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 3'd4;

endpackage

// File: rtl/cc_shift.sv
module cc_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stb,
  input  logic              din,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] word_q, word_d;
  logic              word_en;

  always_comb begin
    word_en = clr | stb;
    word_d  = word_q;
    if (clr) begin
      word_d = '0;
    end else if (stb) begin
      word_d = {din, word_q[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign word = word_q;

  // R1
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !clr) |=> (word[WORD_W-1] == $past(din)));

  // R1
  shift_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (word == '0));

endmodule

// File: rtl/cc_line_track.sv
module cc_line_track #(
  parameter int LINE_W  = 5,
  parameter int CC_LINE = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsep,
  input  logic              line_start,
  input  logic [LINE_W-1:0] prog_line,
  output logic              vfall,
  output logic              end_evt,
  output logic              hit_cc,
  output logic              hit_prog
);

  localparam int               CNT_W   = LINE_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CC_VAL  = CNT_W'(CC_LINE);

  logic             vsep_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign vfall   = vsep_q & ~vsep;
  assign end_evt = line_start & ~vfall;

  always_comb begin
    cnt_en = vfall | (line_start & (cnt_q != CNT_MAX));
    cnt_d  = vfall ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsep_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      vsep_q <= vsep;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign hit_cc   = (cnt_q == CC_VAL);
  assign hit_prog = (cnt_q == {1'b0, prog_line}) && (prog_line != '0);

  // R3
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vfall |=> (cnt_q == '0));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !vfall) |=> $stable(cnt_q));

endmodule

// File: rtl/cc_route.sv
module cc_route
  import cc_cap_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vfall,
  input  logic              end_evt,
  input  logic              hit_cc,
  input  logic              hit_prog,
  input  slice_mode_e       mode,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] pair_a,
  output logic [WORD_W-1:0] pair_b,
  output logic              flag_a,
  output logic              flag_b,
  output logic              irq
);

  logic              sel_a, sel_b, fire;
  logic              a_en, b_en;
  logic [WORD_W-1:0] pair_a_q, pair_a_d, pair_b_q, pair_b_d;
  logic              flag_a_q, flag_a_d, flag_b_q, flag_b_d;
  logic              irq_q, irq_d;

  always_comb begin
    unique case (mode)
      MODE_PROG_ONLY: begin sel_a = hit_prog; sel_b = 1'b0;     fire = hit_prog; end
      MODE_CC_ONLY:   begin sel_a = hit_cc;   sel_b = 1'b0;     fire = hit_cc;   end
      default:        begin sel_a = hit_cc;   sel_b = hit_prog; fire = hit_cc;   end
    endcase
  end

  always_comb begin
    a_en     = vfall | (end_evt & sel_a);
    b_en     = vfall | (end_evt & sel_b);
    pair_a_d = vfall ? '0 : word;
    pair_b_d = vfall ? '0 : word;
    flag_a_d = ~vfall;
    flag_b_d = ~vfall;
    irq_d    = end_evt & fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_a_q <= '0;
      flag_a_q <= 1'b0;
    end else if (a_en) begin
      pair_a_q <= pair_a_d;
      flag_a_q <= flag_a_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_b_q <= '0;
      flag_b_q <= 1'b0;
    end else if (b_en) begin
      pair_b_q <= pair_b_d;
      flag_b_q <= flag_b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign pair_a = pair_a_q;
  assign pair_b = pair_b_q;
  assign flag_a = flag_a_q;
  assign flag_b = flag_b_q;
  assign irq    = irq_q;

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_a);

  // R8
  field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vfall |=> (pair_a == '0 && pair_b == '0 && !flag_a && !flag_b && !irq));

  // R5 R6
  pair_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && (mode == MODE_PROG_ONLY || mode == MODE_CC_ONLY)) |=>
      ($stable(pair_b) && $stable(flag_b)));

  // R9
  midline_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!end_evt && !vfall) |=> ($stable(pair_a) && $stable(pair_b)));

endmodule

// File: rtl/cc_capture.sv
module cc_capture
  import cc_cap_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int LINE_W  = 5,
  parameter int CC_LINE = 21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vsep,
  input  logic                line_start,
  input  logic                data_stb,
  input  logic                data_bit,
  input  logic [1:0]          mode,
  input  logic [LINE_W-1:0]   prog_line,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [WORD_W/2-1:0] rd_data,
  output logic                irq
);

  localparam int BYTE_W = WORD_W / 2;

  logic              vfall, end_evt, hit_cc, hit_prog;
  logic [WORD_W-1:0] word, pair_a, pair_b;
  logic              flag_a, flag_b;

  cc_line_track #(.LINE_W(LINE_W), .CC_LINE(CC_LINE)) track_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsep       (vsep),
    .line_start (line_start),
    .prog_line  (prog_line),
    .vfall      (vfall),
    .end_evt    (end_evt),
    .hit_cc     (hit_cc),
    .hit_prog   (hit_prog)
  );

  cc_shift #(.WORD_W(WORD_W)) shift_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (line_start | vfall),
    .stb   (data_stb),
    .din   (data_bit),
    .word  (word)
  );

  cc_route #(.WORD_W(WORD_W)) route_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .vfall    (vfall),
    .end_evt  (end_evt),
    .hit_cc   (hit_cc),
    .hit_prog (hit_prog),
    .mode     (slice_mode_e'(mode)),
    .word     (word),
    .pair_a   (pair_a),
    .pair_b   (pair_b),
    .flag_a   (flag_a),
    .flag_b   (flag_b),
    .irq      (irq)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADR_A_LO: rd_data = pair_a[BYTE_W-1:0];
      ADR_A_HI: rd_data = pair_a[WORD_W-1:BYTE_W];
      ADR_B_LO: rd_data = pair_b[BYTE_W-1:0];
      ADR_B_HI: rd_data = pair_b[WORD_W-1:BYTE_W];
      ADR_FLAG: rd_data = {{(BYTE_W-2){1'b0}}, flag_b, flag_a};
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: tb/cc_capture_tb.sv
module cc_capture_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsep = 1'b1;
  logic       line_start = 1'b0;
  logic       data_stb = 1'b0;
  logic       data_bit = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [4:0] prog_line = 5'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] exp_a, exp_b;
  logic        exp_fa, exp_fb;

  always #2 clk = ~clk;

  cc_capture dut_i (
    .clk(clk), .rst_n(rst_n), .vsep(vsep), .line_start(line_start),
    .data_stb(data_stb), .data_bit(data_bit), .mode(mode),
    .prog_line(prog_line), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h mode=%0d prog=%0d", req, act, exp, mode, prog_line);
    end
  endtask

  // R2: reads one address per negedge and compares with the model
  task automatic read_chk(input string req, input logic [2:0] a);
    logic [15:0] e;
    @(negedge clk);
    rd_addr = a;
    #1;
    case (a)
      3'd0: e = {8'h0, exp_a[7:0]};
      3'd1: e = {8'h0, exp_a[15:8]};
      3'd2: e = {8'h0, exp_b[7:0]};
      3'd3: e = {8'h0, exp_b[15:8]};
      3'd4: e = {14'h0, exp_fb, exp_fa};
      default: e = 16'h0;
    endcase
    check(req, {8'h0, rd_data}, e);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 8; a++) read_chk(req, 3'(a));
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    data_stb = 1'b1;
    data_bit = b;
    @(negedge clk);
    data_stb = 1'b0;
  endtask

  task automatic field_start();
    @(negedge clk);
    vsep = 1'b0;
    @(negedge clk);
    vsep = 1'b1;
    exp_a = '0; exp_b = '0; exp_fa = 1'b0; exp_fb = 1'b0;
    #1;
    check("R8 irq after sync fall", {15'h0, irq}, 16'h0);
    read_all("R8 clear on sync fall");
  endtask

  // one line: junk bits, then 16 word bits LSB-first, then the line start ending it
  task automatic run_line(input int ln, input logic [15:0] w);
    logic is21, isp, exp_irq;
    for (int j = 0; j < (ln % 3) * 2; j++) send_bit(~w[j]);
    for (int i = 0; i < 16; i++) begin
      send_bit(w[i]);
      if (i == 8) begin
        read_chk("R9 mid-line pair A", 3'd0);
        read_chk("R9 mid-line pair B", 3'd2);
      end
    end
    @(negedge clk);
    line_start = 1'b1;
    data_stb = 1'b1;
    data_bit = 1'b1;  // R1: dropped bit on the line start cycle
    @(negedge clk);
    line_start = 1'b0;
    data_stb = 1'b0;
    is21 = (ln == 21);
    isp = (ln == int'(prog_line)) && (prog_line != 5'd0);
    case (mode)
      2'b01: begin
        if (isp) begin exp_a = w; exp_fa = 1'b1; end
        exp_irq = isp;
      end
      2'b10: begin
        if (is21) begin exp_a = w; exp_fa = 1'b1; end
        exp_irq = is21;
      end
      default: begin
        if (is21) begin exp_a = w; exp_fa = 1'b1; end
        if (isp) begin exp_b = w; exp_fb = 1'b1; end
        exp_irq = is21;
      end
    endcase
    #1;
    check("R7 irq pulse", {15'h0, irq}, {15'h0, exp_irq});
    @(negedge clk);
    #1;
    check("R7 irq one cycle", {15'h0, irq}, 16'h0);
    for (int a = 0; a < 5; a++) read_chk("R1 R3 R4 R5 R6 latched data", 3'(a));
  endtask

  function automatic logic [15:0] gen_word(input int ln, input int fld);
    return 16'((ln * 40503 + fld * 4660 + 257) ^ (ln << 11));
  endfunction

  initial begin
    exp_a = '0; exp_b = '0; exp_fa = 1'b0; exp_fb = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R10 irq at reset", {15'h0, irq}, 16'h0);
    read_chk("R10 reset pair A low", 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    read_all("R10 reset read map R2");

    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        int fld;
        fld = m * 4 + p;
        @(negedge clk);
        mode = 2'(m);
        case (p)
          0: prog_line = 5'd0;
          1: prog_line = 5'd3;
          2: prog_line = 5'd21;
          default: prog_line = 5'd31;
        endcase
        field_start();
        for (int ln = 0; ln < 34; ln++) run_line(ln, gen_word(ln, fld));
      end
    end

    // R8: sync fall coinciding with the line start that ends line 21
    @(negedge clk);
    mode = 2'b00;
    prog_line = 5'd21;
    field_start();
    for (int ln = 0; ln < 21; ln++) run_line(ln, gen_word(ln, 99));
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    @(negedge clk);
    vsep = 1'b0;
    line_start = 1'b1;
    @(negedge clk);
    vsep = 1'b1;
    line_start = 1'b0;
    exp_a = '0; exp_b = '0; exp_fa = 1'b0; exp_fb = 1'b0;
    #1;
    check("R8 no irq on collision", {15'h0, irq}, 16'h0);
    read_all("R8 collision clears");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired before completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule